// File: doc/BRIEF.md
# Input-Queued Crossbar Switch with Head-of-Line Blocking

This block is a four-by-four packet switch in which every input port keeps a first-in first-out queue of packet descriptors. A descriptor holds only a destination output number and an opaque tag, and no payload moves. Upstream logic writes descriptors into a queue through a per-input enqueue port. Each queue reports when it is full. A refused write is flagged with a drop pulse in the same cycle.

Transfers happen only on cycles where the slot strobe is high. In such a cycle the fabric looks at the head descriptor of each non-empty queue. Each output picks at most one requesting input with its own rotating-priority arbiter. Every winning head then crosses the fabric in parallel. A losing head stays at the front of its queue, and so does everything behind it, even when those later descriptors target idle outputs. This head-of-line blocking is intended behaviour: the block is meant to reproduce it. In the cycle after the slot, each output that received a descriptor presents its tag and source input for one cycle.

Top module: `xbar_hol_switch`

## Requirements
- R1: In a single slot, each output accepts a descriptor from at most one input.
- R2: Heads whose destination outputs are all different all transfer in the same slot.
- R3: A head that loses arbitration stays at the front of its queue. It competes again in the next slot.
- R4: Each queue is served in arrival order and only its head is eligible. A descriptor behind a blocked head does not move, even if its own output has no requester.
- R5: A transfer takes one slot. `out_valid[o]` is high for exactly the one cycle that follows the strobed cycle, with `out_tag[o]` and `out_src[o]` (the input index, 0 to 3) of the moved descriptor. At all other times it is low.
- R6: Each output arbiter keeps a priority pointer that is 0 after reset. It grants the first requesting input at or after the pointer, wrapping upward from 3 to 0. After a grant the pointer moves to the granted input plus one, modulo 4.
- R7: A queue holds 8 descriptors, and `enq_full[i]` is high while it holds 8. A write while full raises `enq_drop[i]` in that same cycle and is discarded, leaving the queue contents unchanged.
- R8: Without the slot strobe no descriptor moves. Writing descriptors produces no output activity.
- R9: After reset all queues are empty, `enq_full` is low and every `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot | input | 1 | Time-slot strobe; arbitration and transfer happen in this cycle |
| enq_valid | input | 4 | Per-input write request |
| enq_dest | input | 4x2 | Per-input destination output of the written descriptor |
| enq_tag | input | 4x8 | Per-input tag of the written descriptor |
| enq_full | output | 4 | Per-input queue holds 8 descriptors |
| enq_drop | output | 4 | Per-input write refused this cycle because the queue is full |
| out_valid | output | 4 | Per-output descriptor delivered (one cycle after the slot) |
| out_tag | output | 4x8 | Per-output tag of the delivered descriptor |
| out_src | output | 4x2 | Per-output source input index of the delivered descriptor |

## Verification
The bench builds the switch with its default values: four ports, 8-bit tags and a queue depth of 8. With a depth of 8, one input can be driven past full and drained entirely within a few dozen cycles, so the drop path and the in-order drain are both reachable. With four ports, every pointer position of a rotating arbiter comes into play when all inputs target one output. Four ports also allow a three-way contention to run alongside an idle output, which makes head-of-line blocking observable at the ports.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int NPORT  = 4;
    localparam int TAG_W  = 8;
    localparam int QDEPTH = 8;
    localparam int PORT_W = $clog2(NPORT);

    typedef logic [PORT_W-1:0] port_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // Descriptor held in an input queue
    typedef struct packed {
        port_t dest;
        tag_t  tag;
    } desc_t;

    // Record presented on an output after a slot
    typedef struct packed {
        logic  valid;
        port_t src;
        tag_t  tag;
    } egress_t;

    function automatic port_t port_after(port_t p);
        return (p == port_t'(NPORT - 1)) ? port_t'(0) : port_t'(p + 1'b1);
    endfunction

endpackage

// File: rtl/xbar_fifo.sv
module xbar_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         nonempty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
    endfunction

    assign rdata    = mem[rd_ptr];
    assign nonempty = (count != '0);
    assign full     = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr) wr_ptr <= bump(wr_ptr);
            if (rd) rd_ptr <= bump(rd_ptr);
            case ({wr, rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the queue depth
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R4: a pop is only ever issued for a present head
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        rd |-> nonempty);

    // R7: a write is never accepted into a full queue
    p_no_write_full_r7: assert property (@(posedge clk) disable iff (rst)
        (full && !rd) |-> !wr);

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 advance,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] grant_idx,
    output logic                 grant_any
);
    localparam int PW = $clog2(N);

    logic [PW-1:0] ptr;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!grant_any && req[idx]) begin
                grant_any      = 1'b1;
                grant_idx      = PW'(idx);
                grant[idx]     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance && grant_any) begin
            ptr <= (grant_idx == PW'(N - 1)) ? '0 : PW'(grant_idx + 1'b1);
        end
    end

    // R1: one input at most per output
    p_one_grant_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R1: a grant only goes to a requester
    p_grant_req_r1: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R6: pointer moves only when a grant is taken
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(advance && grant_any) |=> $stable(ptr));

endmodule

// File: rtl/xbar_hol_switch.sv
module xbar_hol_switch
    import xbar_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          slot,
    input  logic [NPORT-1:0]              enq_valid,
    input  logic [NPORT-1:0][PORT_W-1:0]  enq_dest,
    input  logic [NPORT-1:0][TAG_W-1:0]   enq_tag,
    output logic [NPORT-1:0]              enq_full,
    output logic [NPORT-1:0]              enq_drop,
    output logic [NPORT-1:0]              out_valid,
    output logic [NPORT-1:0][TAG_W-1:0]   out_tag,
    output logic [NPORT-1:0][PORT_W-1:0]  out_src
);
    localparam int DW = $bits(desc_t);

    desc_t                    q_head   [NPORT];
    logic [NPORT-1:0]         q_valid;
    logic [NPORT-1:0]         q_full;
    logic [NPORT-1:0]         q_wr;
    logic [NPORT-1:0]         pop;
    logic [NPORT-1:0]         granted_in;
    logic [NPORT-1:0]         req_m    [NPORT];
    logic [NPORT-1:0]         grant_m  [NPORT];
    port_t                    gidx     [NPORT];
    logic [NPORT-1:0]         gany;
    egress_t                  egress   [NPORT];

    // ---------------- input queues ----------------
    for (genvar i = 0; i < NPORT; i++) begin : g_in
        desc_t wdesc;
        logic [DW-1:0] rdata;

        assign wdesc.dest = enq_dest[i];
        assign wdesc.tag  = enq_tag[i];
        assign q_wr[i]     = enq_valid[i] && !q_full[i];
        assign enq_drop[i] = enq_valid[i] && q_full[i];
        assign enq_full[i] = q_full[i];
        assign q_head[i]   = desc_t'(rdata);
        assign pop[i]      = slot && granted_in[i];

        xbar_fifo #(.W(DW), .DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst      (rst),
            .wr       (q_wr[i]),
            .wdata    (wdesc),
            .rd       (pop[i]),
            .rdata    (rdata),
            .nonempty (q_valid[i]),
            .full     (q_full[i])
        );

        // R3: an ungranted head stays in place
        p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (q_valid[i] && !pop[i]) |=> (q_valid[i] && $stable(q_head[i])));

        // R7: a refused write leaves a full queue full
        p_drop_keeps_r7: assert property (@(posedge clk) disable iff (rst)
            (enq_drop[i] && !pop[i]) |=> q_full[i]);
    end

    // ---------------- request matrix and arbiters ----------------
    for (genvar o = 0; o < NPORT; o++) begin : g_out
        for (genvar i = 0; i < NPORT; i++) begin : g_req
            assign req_m[o][i] = q_valid[i] && (q_head[i].dest == port_t'(o));
        end

        xbar_rr_arb #(.N(NPORT)) u_arb (
            .clk       (clk),
            .rst       (rst),
            .req       (req_m[o]),
            .advance   (slot),
            .grant     (grant_m[o]),
            .grant_idx (gidx[o]),
            .grant_any (gany[o])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                egress[o] <= '0;
            end else if (slot && gany[o]) begin
                egress[o].valid <= 1'b1;
                egress[o].src   <= gidx[o];
                egress[o].tag   <= q_head[gidx[o]].tag;
            end else begin
                egress[o].valid <= 1'b0;
            end
        end

        assign out_valid[o] = egress[o].valid;
        assign out_tag[o]   = egress[o].tag;
        assign out_src[o]   = egress[o].src;

        // R5: an output pulse always follows a strobed cycle
        p_out_after_slot_r5: assert property (@(posedge clk) disable iff (rst)
            out_valid[o] |-> $past(slot));
    end

    always_comb begin
        granted_in = '0;
        for (int o = 0; o < NPORT; o++) begin
            granted_in = granted_in | grant_m[o];
        end
    end

    // R8: nothing leaves a queue outside a slot
    p_no_move_r8: assert property (@(posedge clk) disable iff (rst)
        !slot |-> (pop == '0));

endmodule

// File: tb/xbar_hol_switch_test.sv
module xbar_hol_switch_test;
    import xbar_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot = 1'b0;
    logic [NPORT-1:0]             enq_valid = '0;
    logic [NPORT-1:0][PORT_W-1:0] enq_dest  = '0;
    logic [NPORT-1:0][TAG_W-1:0]  enq_tag   = '0;
    logic [NPORT-1:0]             enq_full;
    logic [NPORT-1:0]             enq_drop;
    logic [NPORT-1:0]             out_valid;
    logic [NPORT-1:0][TAG_W-1:0]  out_tag;
    logic [NPORT-1:0][PORT_W-1:0] out_src;

    always #2 clk = ~clk;

    xbar_hol_switch uut (
        .clk(clk), .rst(rst), .slot(slot),
        .enq_valid(enq_valid), .enq_dest(enq_dest), .enq_tag(enq_tag),
        .enq_full(enq_full), .enq_drop(enq_drop),
        .out_valid(out_valid), .out_tag(out_tag), .out_src(out_src)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference queues and pointers
    int mqd [NPORT][$];
    int mqt [NPORT][$];
    int mptr [NPORT];

    typedef struct { int o; int t; int s; } exp_t;
    exp_t expq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic enq(input int i, input int d, input int t, input string req);
        bit exp_drop;
        @(negedge clk);
        slot = 1'b0;
        enq_valid = '0;
        enq_valid[i] = 1'b1;
        enq_dest[i]  = PORT_W'(d);
        enq_tag[i]   = TAG_W'(t);
        #1;
        exp_drop = (mqd[i].size() == QDEPTH);
        check(enq_drop[i] == exp_drop, req, $sformatf("drop in%0d", i),
              int'(enq_drop[i]), int'(exp_drop));
        if (!exp_drop) begin
            mqd[i].push_back(d);
            mqt[i].push_back(t);
        end
    endtask

    task automatic quiet(input string req);
        @(negedge clk);
        enq_valid = '0;
        slot = 1'b0;
        for (int o = 0; o < NPORT; o++)
            check(out_valid[o] == 1'b0, req, $sformatf("idle out%0d valid", o),
                  int'(out_valid[o]), 0);
    endtask

    // driver: strobe a slot and push the expected deliveries
    task automatic do_slot(input string req);
        int g [NPORT];
        @(negedge clk);
        enq_valid = '0;
        slot = 1'b1;
        for (int o = 0; o < NPORT; o++) begin
            g[o] = -1;
            for (int k = 0; k < NPORT; k++) begin
                int idx;
                idx = (mptr[o] + k) % NPORT;
                if (g[o] < 0 && mqd[idx].size() > 0 && mqd[idx][0] == o) g[o] = idx;
            end
        end
        for (int o = 0; o < NPORT; o++) begin
            if (g[o] >= 0) begin
                exp_t e;
                e.o = o; e.t = mqt[g[o]][0]; e.s = g[o];
                expq.push_back(e);
                mptr[o] = (g[o] + 1) % NPORT;
                void'(mqd[g[o]].pop_front());
                void'(mqt[g[o]].pop_front());
            end
        end
        @(negedge clk);
        slot = 1'b0;
        monitor(req);
    endtask

    // monitor: pop the scoreboard and compare against the outputs
    task automatic monitor(input string req);
        bit [NPORT-1:0] seen = '0;
        while (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            seen[e.o] = 1'b1;
            check(out_valid[e.o] == 1'b1, req, $sformatf("out%0d valid", e.o),
                  int'(out_valid[e.o]), 1);
            check(int'(out_tag[e.o]) == e.t, req, $sformatf("out%0d tag", e.o),
                  int'(out_tag[e.o]), e.t);
            check(int'(out_src[e.o]) == e.s, req, $sformatf("out%0d src", e.o),
                  int'(out_src[e.o]), e.s);
        end
        for (int o = 0; o < NPORT; o++)
            if (!seen[o])
                check(out_valid[o] == 1'b0, req, $sformatf("out%0d quiet", o),
                      int'(out_valid[o]), 0);
    endtask

    initial begin
        for (int o = 0; o < NPORT; o++) mptr[o] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        #1;
        check(out_valid == '0, "R9", "out_valid", int'(out_valid), 0);
        check(enq_full == '0, "R9", "enq_full", int'(enq_full), 0);

        // R8: writes alone cause no output
        enq(0, 2, 8'h10, "R8");
        enq(1, 3, 8'h11, "R8");
        enq(2, 0, 8'h12, "R8");
        enq(3, 1, 8'h13, "R8");
        quiet("R8");
        quiet("R8");

        // R2: four distinct destinations move together
        do_slot("R2");
        quiet("R5");

        // R3/R4: three heads to out1, in1 holds a second entry for idle out3
        enq(0, 1, 8'h20, "R3");
        enq(1, 1, 8'h21, "R3");
        enq(1, 3, 8'h22, "R4");
        enq(2, 1, 8'h23, "R3");
        do_slot("R1");
        // hand-derived: in0 wins out1, in1's entry for out3 is stuck behind
        check(out_valid[1] && out_src[1] == 2'd0, "R1", "out1 src in0",
              int'(out_src[1]), 0);
        check(out_valid[3] == 1'b0, "R4", "out3 blocked by HOL",
              int'(out_valid[3]), 0);
        do_slot("R3");
        do_slot("R4");
        quiet("R5");

        // R6: all inputs target out0, grants rotate
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < NPORT; i++)
                enq(i, 0, 8'h40 + r * 4 + i, "R6");
        for (int s = 0; s < 8; s++) do_slot("R6");
        quiet("R6");

        // R7: fill input 3, overflow, drain in order
        for (int k = 0; k < QDEPTH; k++) enq(3, 2, 8'h60 + k, "R7");
        quiet("R7");
        check(enq_full[3] == 1'b1, "R7", "full at depth", int'(enq_full[3]), 1);
        check(enq_full[2:0] == 3'b000, "R7", "others not full",
              int'(enq_full[2:0]), 0);
        enq(3, 2, 8'hEE, "R7");
        quiet("R7");
        for (int k = 0; k < QDEPTH; k++) do_slot("R7");
        do_slot("R7");
        quiet("R7");
        check(enq_full[3] == 1'b0, "R7", "full after drain", int'(enq_full[3]), 0);

        // R5: back-to-back slots each deliver once
        enq(2, 3, 8'h71, "R5");
        enq(2, 3, 8'h72, "R5");
        do_slot("R5");
        do_slot("R5");
        quiet("R5");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule